// File: doc/BRIEF.md
# Clock Generator PLL Sequencer

This block is the digital control and status logic for a clock generator. Software programs it through a small synchronous register port. Through that port it chooses whether the system clocks come from the PLL or straight from the reference. It also holds the PLL multiplier code, resets and powers down the PLL, and asks for the oscillator to power down. The analog PLL and oscillator are not part of the block. A lock-delay counter stands in for phase acquisition, and a fixed reference-cycle counter decides when the oscillator output counts as stable.

Oscillator power-down follows one of two policies, chosen by the `clk_mode` input. In immediate mode the oscillator stops on the cycle after the request. In deferred mode it waits until the clock generator reports idle. Once stopped, the oscillator stays down until software withdraws the request. The port has no streaming data, so every pin is a plain level. A register read returns its data one cycle after the address is presented.

Register map: address 0 is the control/status word. Its bits are: bit 0 clock-source select, bit 1 PLL power-down, bit 2 oscillator power-down request, bit 3 PLL reset, bit 5 lock (read-only), bit 6 oscillator stable (read-only), and 0 for the other bits. Address 1 holds the multiplier code in bits 4:0 and reads 0 above that.

Top module: `clkgen_ctl`

## Requirements
- R1: After reset the block selects bypass, holds PLL reset asserted, requests no power-down, reads multiplier code 2, and shows lock 0 and stable 0.
- R2: With the oscillator running and no override, `osc_stable_o` goes to 1 exactly STABLE_CYCLES (41032) reference edges after the oscillator starts. It is 0 before that, and it falls within two cycles of the oscillator stopping.
- R3: `osc_stable_o` reads 1 whenever `stab_cnt_dis` or `test_mode` is 1, even while the oscillator is stopped.
- R4: `pll_lock_o` is 0 while acquiring. It rises exactly LOCK_CYCLES edges after the edge that released PLL reset, with the PLL powered.
- R5: An accepted multiplier write, or a control write that sets PLL reset or PLL power-down, drops `pll_lock_o` on that same edge and restarts acquisition.
- R6: Control bit 3 is read/write. Its value appears on `pll_rst_o` after the writing edge: 1 asserts PLL reset and 0 releases it.
- R7: When bit 2 is set and `clk_mode` is 1, `osc_pwrdn_o` rises one edge after the request bit takes effect.
- R8: When bit 2 is set and `clk_mode` is 0, `osc_pwrdn_o` waits for `idle_flag`=1 and then stays 1 even if idle drops. Clearing bit 2 restarts the oscillator on the next edge.
- R9: Control bit 1 drives `pll_pwrdn_o` (1 = PLL powered down).
- R10: Control bit 0 drives `pll_sel_o`: 0 = system clocks from the reference (bypass), 1 = from the PLL output.
- R11: Multiplier codes 2 to 15 are stored and driven on `mult_o`. Codes 0, 1 and 16 to 31 are ignored and the previous code is kept.
- R12: Writes to bits 5 and 6 of address 0 have no effect. `reg_rdata` shows the addressed word one edge after `reg_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| clk_mode | input | 1 | 1 = immediate oscillator power-down, 0 = wait for idle |
| idle_flag | input | 1 | Clock generator has entered idle |
| stab_cnt_dis | input | 1 | Stability counter disabled |
| test_mode | input | 1 | Test mode active |
| pll_sel_o | output | 1 | 1 = PLL output drives the system clocks |
| pll_pwrdn_o | output | 1 | PLL power-down |
| pll_rst_o | output | 1 | PLL reset |
| osc_pwrdn_o | output | 1 | Oscillator power-down |
| mult_o | output | 5 | Multiplier code |
| pll_lock_o | output | 1 | PLL lock status |
| osc_stable_o | output | 1 | Oscillator stable status |

## Verification
A wrong internal state shows up at the pins within a few edges in most cases. A lost or stray power-down request appears on `osc_pwrdn_o` one edge later. A corrupted multiplier appears at once on `mult_o` and on the readback. The two counters are the slow cases. A lock counter that fails to restart shows up only after LOCK_CYCLES, as a lock that stays high or rises early. A stability counter error is visible only at its 41032-edge boundary, so the bench samples both counters one edge before and at their terminal count.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int DATA_W    = 16;
  localparam int MULT_W    = 5;
  localparam int MULT_MIN  = 2;
  localparam int MULT_MAX  = 15;
  localparam int MULT_RST  = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MULT = 2'd1;

  localparam int B_SEL    = 0;
  localparam int B_PLLPD  = 1;
  localparam int B_OSCPD  = 2;
  localparam int B_PLLRST = 3;
  localparam int B_LOCK   = 5;
  localparam int B_STABLE = 6;

  typedef struct packed {
    logic sel;
    logic pll_pd;
    logic osc_req;
    logic pll_rst;
  } ctrl_t;
endpackage

// File: rtl/clkgen_stab.sv
module clkgen_stab #(
  parameter int CYCLES = 41032
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_off,
  input  logic cnt_dis,
  input  logic test_mode,
  output logic stable_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES);

  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk) begin
    if (!rst_n || osc_off) cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign done     = (cnt == LAST);
  assign stable_o = done | cnt_dis | test_mode;

  AST_OFF_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |=> !done); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !osc_off) |=> done); // R2
endmodule

// File: rtl/clkgen_lock.sv
module clkgen_lock #(
  parameter int CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic hold,
  output logic lock_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || hold) cnt <= '0;
    else if (cnt != LAST)          cnt <= cnt + 1'b1;
  end

  assign lock_o = (cnt == LAST);

  AST_RESTART_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !lock_o); // R5
  AST_HOLD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !lock_o); // R4
  AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !restart && !hold) |=> lock_o); // R4
endmodule

// File: rtl/clkgen_oscpd.sv
module clkgen_oscpd (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic immediate,
  input  logic idle,
  output logic off_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) off_o <= 1'b0;
    else        off_o <= req & (off_o | immediate | idle);
  end

  AST_IMMEDIATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req && immediate) |=> off_o); // R7
  AST_DEFER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_o && !immediate && !idle) |=> !off_o); // R8
  AST_RELEASE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !off_o); // R8
endmodule

// File: rtl/clkgen_ctl.sv
module clkgen_ctl
  import clkgen_pkg::*;
#(
  parameter int ADDR_W        = 2,
  parameter int STABLE_CYCLES = 41032,
  parameter int LOCK_CYCLES   = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                clk_mode,
  input  logic                idle_flag,
  input  logic                stab_cnt_dis,
  input  logic                test_mode,
  output logic                pll_sel_o,
  output logic                pll_pwrdn_o,
  output logic                pll_rst_o,
  output logic                osc_pwrdn_o,
  output logic [MULT_W-1:0]   mult_o,
  output logic                pll_lock_o,
  output logic                osc_stable_o
);
  ctrl_t             ctrl_q;
  logic [MULT_W-1:0] mult_q;
  logic              wr_ctrl, wr_mult, mult_ok, lock_restart, lock_hold;
  logic [MULT_W-1:0] mult_in;

  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign wr_mult = reg_we && (reg_addr == ADDR_W'(ADDR_MULT));
  assign mult_in = reg_wdata[MULT_W-1:0];
  assign mult_ok = (mult_in >= MULT_W'(MULT_MIN)) && (mult_in <= MULT_W'(MULT_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '{sel: 1'b0, pll_pd: 1'b0, osc_req: 1'b0, pll_rst: 1'b1};
      mult_q <= MULT_W'(MULT_RST);
    end else begin
      if (wr_ctrl) begin
        ctrl_q.sel     <= reg_wdata[B_SEL];
        ctrl_q.pll_pd  <= reg_wdata[B_PLLPD];
        ctrl_q.osc_req <= reg_wdata[B_OSCPD];
        ctrl_q.pll_rst <= reg_wdata[B_PLLRST];
      end
      if (wr_mult && mult_ok) mult_q <= mult_in;
    end
  end

  assign lock_restart = (wr_mult && mult_ok)
                      || (wr_ctrl && (reg_wdata[B_PLLRST] || reg_wdata[B_PLLPD]));
  assign lock_hold    = ctrl_q.pll_rst | ctrl_q.pll_pd;

  clkgen_lock #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .restart(lock_restart), .hold(lock_hold),
    .lock_o(pll_lock_o)
  );

  clkgen_oscpd u_oscpd (
    .clk(clk), .rst_n(rst_n), .req(ctrl_q.osc_req), .immediate(clk_mode),
    .idle(idle_flag), .off_o(osc_pwrdn_o)
  );

  clkgen_stab #(.CYCLES(STABLE_CYCLES)) u_stab (
    .clk(clk), .rst_n(rst_n), .osc_off(osc_pwrdn_o), .cnt_dis(stab_cnt_dis),
    .test_mode(test_mode), .stable_o(osc_stable_o)
  );

  assign pll_sel_o   = ctrl_q.sel;
  assign pll_pwrdn_o = ctrl_q.pll_pd;
  assign pll_rst_o   = ctrl_q.pll_rst;
  assign mult_o      = mult_q;

  logic [DATA_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word           = '0;
    ctrl_word[B_SEL]    = ctrl_q.sel;
    ctrl_word[B_PLLPD]  = ctrl_q.pll_pd;
    ctrl_word[B_OSCPD]  = ctrl_q.osc_req;
    ctrl_word[B_PLLRST] = ctrl_q.pll_rst;
    ctrl_word[B_LOCK]   = pll_lock_o;
    ctrl_word[B_STABLE] = osc_stable_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                 reg_rdata <= '0;
    else if (reg_addr == ADDR_W'(ADDR_CTRL))    reg_rdata <= ctrl_word;
    else if (reg_addr == ADDR_W'(ADDR_MULT))    reg_rdata <= DATA_W'(mult_q);
    else                                        reg_rdata <= '0;
  end

  AST_MULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_o >= MULT_W'(MULT_MIN)) && (mult_o <= MULT_W'(MULT_MAX))); // R11
  AST_MULT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mult && mult_ok) |=> $stable(mult_o)); // R11
  AST_RST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (pll_rst_o == $past(reg_wdata[B_PLLRST]))); // R6
endmodule

// File: tb/clkgen_ctl_tb.sv
module clkgen_ctl_tb;
  localparam int SC = 41032;
  localparam int LC = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        clk_mode = 1'b1, idle_flag = 1'b0, stab_cnt_dis = 1'b0, test_mode = 1'b0;
  logic        pll_sel_o, pll_pwrdn_o, pll_rst_o, osc_pwrdn_o, pll_lock_o, osc_stable_o;
  logic [4:0]  mult_o;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) edges++;

  clkgen_ctl #(.STABLE_CYCLES(SC), .LOCK_CYCLES(LC)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_mode(clk_mode),
    .idle_flag(idle_flag), .stab_cnt_dis(stab_cnt_dis), .test_mode(test_mode),
    .pll_sel_o(pll_sel_o), .pll_pwrdn_o(pll_pwrdn_o), .pll_rst_o(pll_rst_o),
    .osc_pwrdn_o(osc_pwrdn_o), .mult_o(mult_o), .pll_lock_o(pll_lock_o),
    .osc_stable_o(osc_stable_o)
  );

  // {code written, expected mult after, accepted}
  localparam logic [10:0] VEC [8] = '{
    {5'd5,  5'd5,  1'b1}, {5'd0,  5'd5,  1'b0}, {5'd15, 5'd15, 1'b1},
    {5'd1,  5'd15, 1'b0}, {5'd16, 5'd15, 1'b0}, {5'd9,  5'd9,  1'b1},
    {5'd31, 5'd9,  1'b0}, {5'd2,  5'd2,  1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_lock();
    repeat (LC + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sel", 16'(pll_sel_o), 16'd0);
    check("R1 rst", 16'(pll_rst_o), 16'd1);
    check("R1 pd", 16'({pll_pwrdn_o, osc_pwrdn_o}), 16'd0);
    check("R1 lock", 16'(pll_lock_o), 16'd0);
    rd(2'd0, d); check("R1 ctrl word", d, 16'h0008);
    rd(2'd1, d); check("R1 mult", d, 16'd2);

    // R2 stable boundary
    while (edges < SC - 1) @(negedge clk);
    check("R2 before count", 16'(osc_stable_o), 16'd0);
    @(negedge clk);
    check("R2 at count", 16'(osc_stable_o), 16'd1);

    // R6/R4 release PLL reset, lock timing
    wr(2'd0, 16'h0000);
    check("R6 rst released", 16'(pll_rst_o), 16'd0);
    repeat (LC - 1) @(negedge clk);
    check("R4 still acquiring", 16'(pll_lock_o), 16'd0);
    @(negedge clk);
    check("R4 locked", 16'(pll_lock_o), 16'd1);

    // R11/R5 multiplier table
    foreach (VEC[i]) begin
      wait_lock();
      wr(2'd1, 16'(VEC[i][10:6]));
      check("R5 lock after mult write", 16'(pll_lock_o), 16'(!VEC[i][0]));
      rd(2'd1, d);
      check("R11 mult readback", d, 16'(VEC[i][5:1]));
      check("R11 mult pins", 16'(mult_o), 16'(VEC[i][5:1]));
    end

    // R12 status bits read-only, R10 select
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0061);
    check("R12 lock not written", 16'(pll_lock_o), 16'd0);
    check("R10 pll selected", 16'(pll_sel_o), 16'd1);
    rd(2'd0, d); check("R12 ctrl readback", d, 16'h0041);

    // R9/R5 PLL power-down
    wait_lock();
    check("R4 relocked", 16'(pll_lock_o), 16'd1);
    wr(2'd0, 16'h0003);
    check("R9 pll pwrdn", 16'(pll_pwrdn_o), 16'd1);
    check("R5 pd unlocks", 16'(pll_lock_o), 16'd0);
    wait_lock();
    check("R4 no lock in pd", 16'(pll_lock_o), 16'd0);
    wr(2'd0, 16'h0000);
    check("R10 bypass", 16'(pll_sel_o), 16'd0);
    wait_lock();
    // R6 re-assert reset
    wr(2'd0, 16'h0008);
    check("R6 rst asserted", 16'(pll_rst_o), 16'd1);
    check("R5 rst unlocks", 16'(pll_lock_o), 16'd0);

    // R7 immediate oscillator power-down
    clk_mode = 1'b1;
    wr(2'd0, 16'h0004);
    check("R7 not yet off", 16'(osc_pwrdn_o), 16'd0);
    @(negedge clk);
    check("R7 off", 16'(osc_pwrdn_o), 16'd1);
    repeat (2) @(negedge clk);
    check("R2 stable drops", 16'(osc_stable_o), 16'd0);
    test_mode = 1'b1; #1;
    check("R3 test mode", 16'(osc_stable_o), 16'd1);
    test_mode = 1'b0; stab_cnt_dis = 1'b1; #1;
    check("R3 counter disabled", 16'(osc_stable_o), 16'd1);
    stab_cnt_dis = 1'b0;
    wr(2'd0, 16'h0000);
    @(negedge clk);
    check("R8 restart", 16'(osc_pwrdn_o), 16'd0);

    // R8 deferred power-down
    clk_mode = 1'b0; idle_flag = 1'b0;
    wr(2'd0, 16'h0004);
    repeat (5) @(negedge clk);
    check("R8 waits idle", 16'(osc_pwrdn_o), 16'd0);
    idle_flag = 1'b1;
    @(negedge clk);
    check("R8 off on idle", 16'(osc_pwrdn_o), 16'd1);
    idle_flag = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 stays off", 16'(osc_pwrdn_o), 16'd1);
    wr(2'd0, 16'h0000);
    @(negedge clk);
    check("R8 cleared", 16'(osc_pwrdn_o), 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule